// File: doc/BRIEF.md
# Micro-frame index and periodic schedule gate

This block is the host-side keeper of the bus micro-frame count. A 14-bit index advances once per micro-frame tick. The low three bits count micro-frames within a frame and the upper eleven bits hold the frame number. A separate start-of-frame value register follows the frame number. It is kept as its own register so that it can be driven onto the bus without slicing the index.

Software turns the periodic schedule on or off through a command bit. The block does not act on that bit at once. It samples the bit only at the frame boundary, which is the tick that returns the micro-frame field to zero. A status bit then shows the value in force. While the schedule is active, the block raises a one-cycle fetch request at each frame boundary. The request carries the address of the frame-list entry for the new frame. A command write that would change the bit while an earlier change is still pending is refused and sets a sticky error flag.

Software reaches the block through a small register port. Writes take effect at the clock edge. Reads return the addressed register one clock after the address is presented.

Top module: `uframe_sched_ctrl`

## Requirements
- R1: After reset, the index, the start-of-frame value, the command bit, the status bit, the error flag, the list base and fetch_req are all zero.
- R2: Each cycle with uframe_tick high and no accepted index write adds one to the 14-bit index, wrapping from 16383 to 0. The index does not change in a cycle without a tick or a write.
- R3: The start-of-frame value (read address 4, bits [10:0]) always equals index bits [13:3]. It increments on the tick that takes the index low bits from 111 to 000, and this includes the wrap from frame 2047 to frame 0.
- R4: The command bit (address 0, bit 0) is copied into the status bit only on a tick that takes the index low bits to 000. The copy uses the command value held before that clock edge, so a command write in the same cycle as the boundary tick waits for the next boundary.
- R5: The status bit (address 1, bit 0) keeps its value between frame boundaries.
- R6: A command write is illegal when its bit 0 differs from the command bit while the command bit still differs from the status bit. An illegal write leaves the command bit unchanged and sets the error flag (address 1, bit 1), which stays set until reset.
- R7: fetch_req is never high while the status bit is zero.
- R8: When a boundary tick leaves the status bit at one, fetch_req is high for exactly the next clock. In that clock fetch_addr = {base[31:12], new frame number bits [9:0], 2'b00}.
- R9: An index write (address 2, data [13:0]) is accepted only while the status bit is zero. It loads the index and sets the start-of-frame value to data [13:3], and any tick in the same cycle is dropped. While the status bit is one, an index write is ignored.
- R10: Register map: 0 command, 1 status/error, 2 index, 3 list base, 4 start-of-frame value. A base write keeps data bits [31:12], and base reads return zero in bits [11:0]. Unmapped addresses and unused bits read as zero. rd_data shows the register value as it stood before the clock edge that captures rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| fetch_req | output | 1 | Frame-list fetch request pulse |
| fetch_addr | output | 32 | Frame-list entry address |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes each on purpose. In the first pair, a command write arrives on the very tick that closes a frame. The bench loads the index to micro-frame 7 and then writes the command bit together with the tick. It expects the status bit and fetch_req to keep their old values at that boundary and to change only eight ticks later. In the second pair, an index write coincides with a tick. The bench expects the written value to be read back, not that value plus one.

// File: rtl/ufsc_pkg.sv
package ufsc_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CMD   = 3'd0,
    RA_STAT  = 3'd1,
    RA_INDEX = 3'd2,
    RA_BASE  = 3'd3,
    RA_SOFV  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ufsc_index.sv
module ufsc_index #(
  parameter int IDX_W = 14,
  parameter int UF_W  = 3,
  localparam int FR_W = IDX_W - UF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx,
  output logic [FR_W-1:0]  sofv,
  output logic             frame_edge
);
  assign frame_edge = tick && !load && (idx[UF_W-1:0] == {UF_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      sofv <= '0;
    end else if (load) begin
      idx  <= load_val;
      sofv <= load_val[IDX_W-1:UF_W];
    end else begin
      if (tick) idx <= idx + 1'b1;
      if (frame_edge) sofv <= sofv + 1'b1;
    end
  end

  // R3
  sofv_track_chk: assert property (@(posedge clk) disable iff (rst)
    sofv == idx[IDX_W-1:UF_W]);
  // R3
  sofv_step_chk: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> sofv == $past(sofv) + 1'b1);
  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(idx));
endmodule

// File: rtl/ufsc_gate.sv
module ufsc_gate (
  input  logic clk,
  input  logic rst,
  input  logic cmd_wr,
  input  logic cmd_val,
  input  logic frame_edge,
  output logic cmd_en,
  output logic sched_on,
  output logic err_flag
);
  logic illegal;
  assign illegal = cmd_wr && (cmd_val != cmd_en) && (cmd_en != sched_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_en   <= 1'b0;
      sched_on <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (illegal) err_flag <= 1'b1;
      else if (cmd_wr) cmd_en <= cmd_val;
      if (frame_edge) sched_on <= cmd_en;
    end
  end

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_edge |=> $stable(sched_on));
  // R4
  status_take_chk: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> sched_on == $past(cmd_en));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R6
  bad_wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_val != cmd_en && cmd_en != sched_on) |=> ($stable(cmd_en) && err_flag));
endmodule

// File: rtl/ufsc_fetch.sv
module ufsc_fetch #(
  parameter int DATA_W = 32,
  parameter int LIST_W = 10,
  localparam int BASE_LSB = LIST_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_edge,
  input  logic                       cmd_en,
  input  logic                       sched_on,
  input  logic [DATA_W-1:BASE_LSB]   base_hi,
  input  logic [LIST_W-1:0]          frame_lo,
  output logic                       fetch_req,
  output logic [DATA_W-1:0]          fetch_addr
);
  logic [LIST_W-1:0] frame_nxt;
  logic              go;
  assign frame_nxt = frame_lo + 1'b1;
  assign go        = frame_edge && cmd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      fetch_req <= go;
      if (go) fetch_addr <= {base_hi, frame_nxt, 2'b00};
    end
  end

  // R7
  no_idle_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> sched_on);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> !fetch_req);
endmodule

// File: rtl/uframe_sched_ctrl.sv
module uframe_sched_ctrl
  import ufsc_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int UF_W   = 3,
  parameter int LIST_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                uframe_tick,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                fetch_req,
  output logic [DATA_W-1:0]   fetch_addr
);
  localparam int FR_W     = IDX_W - UF_W;
  localparam int BASE_LSB = LIST_W + 2;

  logic [IDX_W-1:0]         idx;
  logic [FR_W-1:0]          sofv;
  logic                     frame_edge;
  logic                     cmd_en, sched_on, err_flag;
  logic [DATA_W-1:BASE_LSB] base_hi;
  logic                     idx_load, cmd_wr;

  assign idx_load = wr_en && (wr_addr == RA_INDEX) && !sched_on;
  assign cmd_wr   = wr_en && (wr_addr == RA_CMD);

  ufsc_index #(.IDX_W(IDX_W), .UF_W(UF_W)) u_index (
    .clk(clk), .rst(rst), .tick(uframe_tick), .load(idx_load),
    .load_val(wr_data[IDX_W-1:0]), .idx(idx), .sofv(sofv),
    .frame_edge(frame_edge)
  );

  ufsc_gate u_gate (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_val(wr_data[0]),
    .frame_edge(frame_edge), .cmd_en(cmd_en), .sched_on(sched_on),
    .err_flag(err_flag)
  );

  ufsc_fetch #(.DATA_W(DATA_W), .LIST_W(LIST_W)) u_fetch (
    .clk(clk), .rst(rst), .frame_edge(frame_edge), .cmd_en(cmd_en),
    .sched_on(sched_on), .base_hi(base_hi),
    .frame_lo(idx[UF_W+LIST_W-1:UF_W]),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) base_hi <= '0;
    else if (wr_en && wr_addr == RA_BASE) base_hi <= wr_data[DATA_W-1:BASE_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        RA_CMD:   rd_data <= DATA_W'(cmd_en);
        RA_STAT:  rd_data <= DATA_W'({err_flag, sched_on});
        RA_INDEX: rd_data <= DATA_W'(idx);
        RA_BASE:  rd_data <= {base_hi, {BASE_LSB{1'b0}}};
        RA_SOFV:  rd_data <= DATA_W'(sofv);
        default:  rd_data <= '0;
      endcase
    end
  end

  // R9
  idx_wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == RA_INDEX && sched_on && !uframe_tick) |=> $stable(idx));
endmodule

// File: tb/sim_uframe_sched_ctrl.sv
module sim_uframe_sched_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, uframe_tick, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, fetch_addr;
  logic        fetch_req;

  uframe_sched_ctrl u0 (
    .clk(clk), .rst(rst), .uframe_tick(uframe_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
  );

  int checks = 0;
  int fails  = 0;
  logic        r1_phase = 1'b0;
  logic [13:0] m_idx;
  logic        m_cmd, m_stat, m_err;
  logic [31:0] m_base;

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_cmd};
      3'd1: return {30'd0, m_err, m_stat};
      3'd2: return {18'd0, m_idx};
      3'd3: return m_base;
      3'd4: return {21'd0, m_idx[13:3]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    if (r1_phase) return "R1";
    case (a)
      3'd0: return "R4";
      3'd1: return "R5/R6";
      3'd2: return "R2/R9";
      3'd3: return "R10";
      3'd4: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic we, input logic [2:0] wa, input logic [31:0] wd);
    logic [31:0] exp_rd, exp_addr;
    logic        ld, bnd, new_stat, exp_req;
    logic [13:0] nidx;
    string       tag;
    uframe_tick = tk; wr_en = we; wr_addr = wa; wr_data = wd;
    exp_rd = model_rd(rd_addr);
    tag    = rd_tag(rd_addr);
    ld       = we && wa == 3'd2 && !m_stat;
    bnd      = tk && !ld && m_idx[2:0] == 3'd7;
    new_stat = bnd ? m_cmd : m_stat;
    exp_req  = bnd && new_stat;
    nidx     = m_idx + 14'd1;
    exp_addr = {m_base[31:12], nidx[12:3], 2'b00};
    @(posedge clk);
    if (we && wa == 3'd0) begin
      if (wd[0] != m_cmd && m_cmd != m_stat) m_err = 1'b1;
      else m_cmd = wd[0];
    end
    if (ld) m_idx = wd[13:0];
    else if (tk) m_idx = nidx;
    if (we && wa == 3'd3) m_base = {wd[31:12], 12'd0};
    m_stat = new_stat;
    @(negedge clk);
    chk(tag, rd_data, exp_rd);
    chk(new_stat ? "R8" : "R7", {31'd0, fetch_req}, {31'd0, exp_req});
    if (exp_req) chk("R8", fetch_addr, exp_addr);
    wr_en = 1'b0; uframe_tick = 1'b0;
    rd_addr = (rd_addr >= 3'd4) ? 3'd0 : rd_addr + 3'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 3'd0, 32'd0);
      step(1'b0, 1'b0, 3'd0, 32'd0);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic do_reset();
    rst = 1'b1; uframe_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_idx = '0; m_cmd = 1'b0; m_stat = 1'b0; m_err = 1'b0; m_base = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset values on every register and on fetch_req
    r1_phase = 1'b1;
    chk("R1", {31'd0, fetch_req}, 32'd0);
    idle(6);
    r1_phase = 1'b0;

    // R10: base register keeps the upper 20 bits only; unmapped reads are zero
    wr(3'd3, 32'hABCD_E123);
    for (int a = 5; a < 8; a++) begin
      rd_addr = 3'(a);
      idle(1);
    end

    // R4 R5 R7 R8 R9: enable and disable from every micro-frame offset
    for (int off = 0; off < 8; off++) begin
      wr(3'd2, 32'((off * 37 + 5) * 8 + off));
      wr(3'd0, 32'd1);
      ticks(10);
      wr(3'd2, 32'd123);           // R9: ignored while the schedule is active
      idle(5);
      wr(3'd0, 32'd0);
      ticks(10);
    end

    // R3: wrap of the index and of the start-of-frame value
    wr(3'd2, 32'd16370);
    wr(3'd0, 32'd1);
    ticks(30);
    wr(3'd0, 32'd0);
    ticks(10);

    // R4: command write in the same cycle as the boundary tick
    wr(3'd2, 32'd7);
    step(1'b1, 1'b1, 3'd0, 32'd1);
    idle(5);
    ticks(9);
    wr(3'd0, 32'd0);
    ticks(9);

    // R9: index write together with a tick; the tick is dropped
    step(1'b1, 1'b1, 3'd2, 32'd100);
    idle(5);
    ticks(3);

    // R6: illegal write while a change is pending
    do_reset();
    idle(1);
    wr(3'd0, 32'd1);
    wr(3'd0, 32'd0);
    idle(5);
    ticks(9);
    wr(3'd0, 32'd1);
    idle(5);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd1);
    idle(5);
    ticks(9);
    idle(5);

    finish_run();
  end
endmodule